// File: doc/BRIEF.md
# Serial ADC Control-Frame Sequencer

This block is the digital side of a successive-approximation converter with a four-wire serial port and a strobe pin. It watches the serial clock and data-in while chip select is low, hunts for the first 1 bit, and gathers an 8-bit control byte behind it. From that byte it takes the input channel, the single-ended or differential pairing, the unipolar or bipolar coding and the clock mode. It drives the track/hold switch at fixed points of the frame.

When the clock mode selects the external serial clock, the block starts the conversion as the byte ends. It raises the strobe for one serial-clock period and then makes one successive-approximation decision on each of the next twelve falling edges. It presents the trial code to an external DAC and reads back one comparator bit. Each decision is shifted out on data-out as soon as it is made, MSB first. The serial clock is sampled by a fast system clock, so all serial edges are detected inside one synchronous domain.

A new start bit may overlap the tail of a running result, so one conversion can complete every 15 serial clocks. A start bit that arrives too early cancels the running conversion.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, data-out, strobe and track are low and both output enables are low while chip select is high.
- R2: Data-in is sampled only on rising serial-clock edges while chip select is low. While no frame is in progress, 0 bits are ignored, and the first 1 bit becomes bit 7 of the control byte, followed by seven more bits MSB first.
- R3: Control byte fields: bits 6..4 name the positive channel, bit 3 is 1 for single-ended and 0 for differential, bit 2 is 1 for unipolar and 0 for bipolar, and bits 1..0 give the clock mode. The fields appear on the outputs after the falling edge that ends the byte. In differential mode the negative channel is the positive channel with bit 0 flipped (pairs 0/1, 2/3, 4/5, 6/7), and `neg_gnd` is 0. In single-ended mode `neg_gnd` is 1 and `in_neg` is 0.
- R4: Track goes high on the falling edge after the 5th control bit and low (hold) on the falling edge after the 8th.
- R5: With clock mode 11, strobe goes high on the falling edge after the 8th control bit and low on the next falling edge. With any other mode there is no strobe and no conversion, and data-out stays 0.
- R6: In external mode, the 12 falling edges after the one that raises the strobe each make one decision, MSB first. Each decision keeps the current trial bit when `cmp_in` is 1 and sets the next lower bit as the new trial. The decision drives data-out at once: 10 data bits followed by 2 sub-LSB bits. `dac_code` ends holding the full result.
- R7: In bipolar mode the first bit shifted out is inverted (two's complement). In unipolar mode the result is straight binary.
- R8: On every falling edge after the last sub-LSB bit, data-out is 0 until a new conversion produces bits.
- R9: While chip select is high, both output enables are low and serial edges are ignored, and the frame state is kept. After chip select falls again, the strobe drives 0.
- R10: A start bit on any rising edge after result bit B3 has been shifted out begins a new frame while the running conversion finishes, allowing one conversion per 15 serial clocks.
- R11: A start bit seen before B3 has been shifted out cancels the running conversion. Data-out is 0 from the next falling edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above the trial code |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for dout |
| strb | output | 1 | Strobe |
| strb_oe | output | 1 | Output enable for strb |
| track | output | 1 | 1 = track/hold tracking, 0 = holding |
| dac_code | output | RES_W+SUB_W | Trial code to the DAC |
| in_pos | output | 3 | Positive input channel |
| in_neg | output | 3 | Negative input channel (differential) |
| neg_gnd | output | 1 | Negative input tied to analog ground |
| bipolar | output | 1 | Two's-complement coding selected |
| clk_mode | output | 2 | Clock mode field of the last control byte |

## Verification
On every cycle, the embedded properties check several timing rules. The strobe lasts one serial period, data-out moves only on a detected falling edge, and no hold arrives while a conversion is still running. They also check that chip select high clears the strobe, that a late start bit leaves the running conversion alive, and that track stays inside the late part of the control byte. The numeric meaning of the result, the field decoding, the exact edge on which track and hold change, the 15-clock overlap and the abort are things only the bench scenarios can show. For these, the bench runs a behavioural model of the pins, drives the comparator from a modelled analog value, and compares the collected serial words.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CTRL_W = 8;
  localparam int CH_W   = 3;
  localparam int PD_W   = 2;
  localparam logic [PD_W-1:0] PD_EXT = 2'b11;

  typedef struct packed {
    logic [CH_W-1:0] sel;
    logic            single;
    logic            unipolar;
    logic [PD_W-1:0] pd;
  } adc_ctrl_t;
endpackage

// File: rtl/adc_sclk_edge.sv
module adc_sclk_edge (
  input  logic clk,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = !cs_ni &&  sclk_i && !sclk_q;
  assign fall_o = !cs_ni && !sclk_i &&  sclk_q;
endmodule

// File: rtl/adc_ctrl_rx.sv
module adc_ctrl_rx
  import adc_seq_pkg::*;
#(
  parameter int TRACK_AT = 5
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      din_i,
  output logic      start_o,
  output logic      hold_o,
  output logic      track_o,
  output adc_ctrl_t byte_o,
  output adc_ctrl_t ctrl_o
);
  localparam int CNT_W = $clog2(CTRL_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] TRK  = CNT_W'(TRACK_AT);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CTRL_W-1:0] sh_q, sh_d;
  logic              track_q, track_d;
  adc_ctrl_t         ctrl_q, ctrl_d;

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    track_d = track_q;
    ctrl_d  = ctrl_q;
    start_o = 1'b0;
    hold_o  = 1'b0;
    if (rise_i) begin
      if (cnt_q == '0) begin
        if (din_i) begin
          start_o = 1'b1;
          sh_d    = {sh_q[CTRL_W-2:0], 1'b1};
          cnt_d   = CNT_W'(1);
        end
      end else if (cnt_q < FULL) begin
        sh_d  = {sh_q[CTRL_W-2:0], din_i};
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (fall_i) begin
      if (cnt_q == TRK) track_d = 1'b1;
      if (cnt_q == FULL) begin
        track_d = 1'b0;
        hold_o  = 1'b1;
        cnt_d   = '0;
        ctrl_d  = adc_ctrl_t'(sh_q[CTRL_W-2:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      track_q <= 1'b0;
      ctrl_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      track_q <= track_d;
      ctrl_q  <= ctrl_d;
    end
  end

  assign track_o = track_q;
  assign ctrl_o  = ctrl_q;
  assign byte_o  = adc_ctrl_t'(sh_q[CTRL_W-2:0]);

  // R4: tracking only happens in the late part of the control byte
  p_track_window_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    track_q |-> (cnt_q >= TRK));
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W = 10,
  parameter int SUB_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   fall_i,
  input  logic                   start_i,
  input  logic                   hold_i,
  input  logic                   ext_i,
  input  logic                   unipolar_i,
  input  logic                   cmp_i,
  output logic                   dout_o,
  output logic                   strb_o,
  output logic [RES_W+SUB_W-1:0] dac_o
);
  localparam int CONV_W   = RES_W + SUB_W;
  localparam int STEP_W   = $clog2(CONV_W + 1);
  localparam int OVL_STEP = RES_W - 3;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(CONV_W - 1);
  localparam logic [STEP_W-1:0] OVL  = STEP_W'(OVL_STEP);

  logic              active_q, active_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CONV_W-1:0] code_q, code_d;
  logic              bip_q, bip_d;
  logic              dout_q, dout_d;
  logic              strb_q, strb_d;
  logic              early_start;

  assign early_start = start_i && active_q && (step_q < OVL);

  always_comb begin
    active_d = active_q;
    step_d   = step_q;
    code_d   = code_q;
    bip_d    = bip_q;
    dout_d   = dout_q;
    strb_d   = strb_q;
    if (cs_ni) strb_d = 1'b0;
    if (early_start) active_d = 1'b0;
    if (fall_i) begin
      strb_d = 1'b0;
      if (active_q) begin
        for (int i = 0; i < CONV_W; i++) begin
          if (i == CONV_W - 1 - int'(step_q)) code_d[i] = cmp_i;
          if (i == CONV_W - 2 - int'(step_q)) code_d[i] = 1'b1;
        end
        dout_d = (step_q == '0 && bip_q) ? !cmp_i : cmp_i;
        step_d = step_q + 1'b1;
        if (step_q == LAST) active_d = 1'b0;
      end else begin
        dout_d = 1'b0;
      end
      if (hold_i && ext_i) begin
        active_d = 1'b1;
        step_d   = '0;
        code_d   = '0;
        code_d[CONV_W-1] = 1'b1;
        bip_d    = !unipolar_i;
        strb_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      step_q   <= '0;
      code_q   <= '0;
      bip_q    <= 1'b0;
      dout_q   <= 1'b0;
      strb_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      step_q   <= step_d;
      code_q   <= code_d;
      bip_q    <= bip_d;
      dout_q   <= dout_d;
      strb_q   <= strb_d;
    end
  end

  assign dout_o = dout_q;
  assign strb_o = strb_q;
  assign dac_o  = code_q;

  p_strobe_one_period_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (fall_i && strb_q) |=> !strb_q);
  p_dout_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !fall_i |=> $stable(dout_q));
  p_no_hold_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    hold_i |-> !active_q);
  p_late_start_keeps_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_i && active_q && !early_start && !fall_i) |=> active_q);
  p_strobe_low_cs_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    cs_ni |=> !strb_q);
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int SUB_W    = 2,
  parameter int TRACK_AT = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   din,
  input  logic                   cmp_in,
  output logic                   dout,
  output logic                   dout_oe,
  output logic                   strb,
  output logic                   strb_oe,
  output logic                   track,
  output logic [RES_W+SUB_W-1:0] dac_code,
  output logic [CH_W-1:0]        in_pos,
  output logic [CH_W-1:0]        in_neg,
  output logic                   neg_gnd,
  output logic                   bipolar,
  output logic [PD_W-1:0]        clk_mode
);
  logic      rst_meta, rst_sync;
  logic      oe_q;
  logic      rise, fall, start, hold;
  adc_ctrl_t byte_now, ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) oe_q <= 1'b0;
    else           oe_q <= !cs_n;
  end

  adc_sclk_edge u_edge (
    .clk(clk), .rst_ni(rst_sync), .cs_ni(cs_n), .sclk_i(sclk),
    .rise_o(rise), .fall_o(fall)
  );

  adc_ctrl_rx #(.TRACK_AT(TRACK_AT)) u_rx (
    .clk(clk), .rst_ni(rst_sync), .rise_i(rise), .fall_i(fall), .din_i(din),
    .start_o(start), .hold_o(hold), .track_o(track),
    .byte_o(byte_now), .ctrl_o(ctrl)
  );

  adc_sar_core #(.RES_W(RES_W), .SUB_W(SUB_W)) u_sar (
    .clk(clk), .rst_ni(rst_sync), .cs_ni(cs_n), .fall_i(fall),
    .start_i(start), .hold_i(hold), .ext_i(byte_now.pd == PD_EXT),
    .unipolar_i(byte_now.unipolar), .cmp_i(cmp_in),
    .dout_o(dout), .strb_o(strb), .dac_o(dac_code)
  );

  assign dout_oe  = oe_q;
  assign strb_oe  = oe_q;
  assign in_pos   = ctrl.sel;
  assign in_neg   = ctrl.single ? '0 : (ctrl.sel ^ CH_W'(1));
  assign neg_gnd  = ctrl.single;
  assign bipolar  = !ctrl.unipolar;
  assign clk_mode = ctrl.pd;
endmodule

// File: tb/adc_frame_seq_tb.sv
module adc_frame_seq_tb;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, din;
  logic dout, dout_oe, strb, strb_oe, track, neg_gnd, bipolar, cmp_in;
  logic [11:0] dac_code;
  logic [2:0]  in_pos, in_neg;
  logic [1:0]  clk_mode;
  int vin;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic last_dout, last_strb, first_strb;

  always #5 clk = ~clk;
  assign cmp_in = (vin >= int'(dac_code));

  adc_frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .cmp_in(cmp_in),
    .dout(dout), .dout_oe(dout_oe), .strb(strb), .strb_oe(strb_oe), .track(track),
    .dac_code(dac_code), .in_pos(in_pos), .in_neg(in_neg), .neg_gnd(neg_gnd),
    .bipolar(bipolar), .clk_mode(clk_mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural pin model
  int m_sq, m_cnt, m_byte, m_fields, m_track, m_conv, m_step, m_res, m_bip, m_dout, m_strb, m_oe;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sq = 0; m_cnt = 0; m_byte = 0; m_fields = 0; m_track = 0; m_conv = 0;
      m_step = 0; m_res = 0; m_bip = 0; m_dout = 0; m_strb = 0; m_oe = 0;
    end else begin
      bit r, f;
      r = !cs_n && sclk && (m_sq == 0);
      f = !cs_n && !sclk && (m_sq == 1);
      m_sq = sclk;
      m_oe = !cs_n;
      if (cs_n) m_strb = 0;
      if (r) begin
        if (m_cnt == 0) begin
          if (din) begin
            if (m_conv != 0 && m_step < 7) m_conv = 0;
            m_cnt = 1; m_byte = 1;
          end
        end else if (m_cnt < 8) begin
          m_byte = ((m_byte << 1) | int'(din)) & 8'hFF;
          m_cnt++;
        end
      end
      if (f) begin
        m_strb = 0;
        if (m_conv != 0) begin
          m_dout = (m_res >> (11 - m_step)) & 1;
          if (m_step == 0 && m_bip != 0) m_dout ^= 1;
          m_step++;
          if (m_step == 12) m_conv = 0;
        end else m_dout = 0;
        if (m_cnt == 5) m_track = 1;
        if (m_cnt == 8) begin
          m_track = 0; m_cnt = 0; m_fields = m_byte & 8'h7F;
          if ((m_byte & 3) == 3) begin
            m_conv = 1; m_step = 0; m_strb = 1; m_res = vin;
            m_bip = ((m_byte >> 2) & 1) ^ 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int pos, sgl;
      pos = (m_fields >> 4) & 7;
      sgl = (m_fields >> 3) & 1;
      chk("R6 dout", dout, m_dout);
      chk("R5 strb", strb, m_strb);
      chk("R9 dout_oe", dout_oe, m_oe);
      chk("R9 strb_oe", strb_oe, m_oe);
      chk("R4 track", track, m_track);
      chk("R3 in_pos", in_pos, pos);
      chk("R3 in_neg", in_neg, sgl != 0 ? 0 : (pos ^ 1));
      chk("R3 neg_gnd", neg_gnd, sgl);
      chk("R7 bipolar", bipolar, ((m_fields >> 2) & 1) ^ 1);
      chk("R3 clk_mode", clk_mode, m_fields & 3);
    end
  end

  task automatic sclk_cycle(input logic b);
    din = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    last_dout = dout;
    last_strb = strb;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sclk_cycle(b[i]);
  endtask

  task automatic collect(output int w);
    w = 0;
    for (int i = 0; i < 12; i++) begin
      sclk_cycle(1'b0);
      if (i == 0) first_strb = last_strb;
      w = (w << 1) | int'(last_dout);
    end
  endtask

  task automatic set_cs(input logic v);
    cs_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired");
    finish_run();
  end

  initial begin
    int w;
    logic [7:0] bb;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; vin = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset dout", dout, 0);
    chk("R1 reset strb", strb, 0);
    chk("R1 reset track", track, 0);
    chk("R1 reset oe", dout_oe | strb_oe, 0);

    // R2, R5, R6, R8: leading zeros, unipolar single-ended channel 5
    set_cs(1'b0);
    vin = 'h2A7;
    for (int i = 0; i < 3; i++) sclk_cycle(1'b0);
    send_byte(8'hDF);
    chk("R5 strobe at hold", last_strb, 1);
    collect(w);
    chk("R5 strobe one period", first_strb, 0);
    chk("R6 result word", w, 'h2A7);
    chk("R6 dac final", dac_code, 'h2A7);
    sclk_cycle(1'b0);
    chk("R8 dout low after tail", last_dout, 0);
    chk("R2 channel after zeros", in_pos, 5);
    set_cs(1'b1);

    // R7, R3: bipolar differential channel 2
    set_cs(1'b0);
    vin = 'h0F3;
    send_byte(8'hA3);
    collect(w);
    chk("R7 bipolar word", w, 'h8F3);
    chk("R3 diff neg", in_neg, 3);
    chk("R3 diff gnd", neg_gnd, 0);
    set_cs(1'b1);

    // R5: non-external mode, no strobe and no data
    set_cs(1'b0);
    send_byte(8'hBD);
    chk("R5 no strobe", last_strb, 0);
    collect(w);
    chk("R5 no data", w, 0);
    chk("R3 mode field", clk_mode, 1);
    set_cs(1'b1);

    // R10: overlapped start after B3, 15 clocks per conversion
    set_cs(1'b0);
    vin = 'h35C;
    send_byte(8'hDF);
    w = 0;
    for (int i = 0; i < 7; i++) begin
      sclk_cycle(1'b0);
      w = (w << 1) | int'(last_dout);
    end
    bb = 8'hA3;
    for (int i = 7; i >= 0; i--) begin
      sclk_cycle(bb[i]);
      if (i >= 3) w = (w << 1) | int'(last_dout);
      if (i == 2) chk("R8 low between results", last_dout, 0);
    end
    chk("R10 first result intact", w, 'h35C);
    chk("R10 second strobe", last_strb, 1);
    collect(w);
    chk("R10 second result", w, 'hB5C);
    set_cs(1'b1);

    // R11: early start bit aborts
    set_cs(1'b0);
    vin = 'hFFF;
    send_byte(8'hDF);
    for (int i = 0; i < 3; i++) sclk_cycle(1'b0);
    bb = 8'hE7;
    for (int i = 7; i >= 0; i--) begin
      sclk_cycle(bb[i]);
      if (i == 7) begin
        chk("R11 aborted dout", last_dout, 0);
        vin = 'h155;
      end
    end
    collect(w);
    chk("R11 new result", w, 'h155);
    set_cs(1'b1);

    // R9: chip select high pauses the frame
    chk("R9 oe off", dout_oe | strb_oe, 0);
    vin = 'h0AA;
    set_cs(1'b0);
    bb = 8'hDF;
    for (int i = 7; i >= 4; i--) sclk_cycle(bb[i]);
    set_cs(1'b1);
    for (int i = 0; i < 3; i++) sclk_cycle(1'b1);
    set_cs(1'b0);
    chk("R9 strobe low after cs", strb, 0);
    for (int i = 3; i >= 0; i--) sclk_cycle(bb[i]);
    chk("R9 strobe resumes", last_strb, 1);
    set_cs(1'b1);
    set_cs(1'b0);
    chk("R9 strobe cleared", strb, 0);
    collect(w);
    chk("R9 paused result", w, 'h0AA);
    chk("R9 fields kept", in_pos, 5);
    set_cs(1'b1);

    finish_run();
  end
endmodule